// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word of one downstream port of a full/low-speed USB host root hub. Software sees a single 32-bit word. Reading it returns the port's connect, enable, suspend, reset, power and low-speed state, together with four sticky change flags. Writing it issues commands. Each command bit acts only when written as 1, and a 0 in any position does nothing. Line-state events arrive as single-cycle strobes on plain control pins: attach, detach, hardware disable and reset completion.

The change flags are set only by hardware events, or when software issues an illegal command on a disconnected port. Ordinary software commands never set them. Software clears each flag by writing 1 to it. A small sequencer times the exit from suspend against a 1 ms tick. It drives resume signalling for `RESUME_MS` ticks, requests one low-speed end-of-packet, and waits `RESYNC_MS` ticks. It then clears suspend, sets the suspend-change flag and pulses `resume_done`.

The register path is a plain register access: a write takes effect on the clock edge of the cycle in which `wr_en` is high, and `rd_data` is always valid with no handshake. There is no streaming data path, so the block has no valid/ready interface and no back-pressure.

Top module: `rh_port_stat_reg`

## Requirements
- R1: After reset, `rd_data` is 0 and `port_reset`, `resume_drive`, `eop_pulse` and `resume_done` are all 0.
- R2: Bit positions in `rd_data` are:
  - bit 0: connected
  - bit 1: enabled
  - bit 2: suspended
  - bit 3: resume in progress
  - bit 4: reset in progress
  - bit 8: powered
  - bit 9: low-speed device
  - bit 16: connect change
  - bit 17: enable change
  - bit 18: suspend change
  - bit 20: reset change

  An `ev_attach` sets bit 0, latches `ls_detect` into bit 9 and sets bit 16. An `ev_detach` clears bits 0, 1, 2, 4 and 9, sets bit 16, and sets bit 17 when the port was enabled. Bit 9 is never 1 while bit 0 is 0.
- R3: Bits 16, 17, 18 and 20 each clear when 1 is written to them. Writing 0 to any of them leaves it unchanged. A hardware event that sets a flag in the same cycle wins over the clear.
- R4: Writing 1 to bit 0 clears the enable without setting bit 17. Writing 1 to bit 1 sets the enable. An `hw_disable` pulse while enabled clears the enable and sets bit 17. An `hw_disable` pulse while disabled changes nothing.
- R5: Writing 1 to bit 1, 2 or 4 while bit 0 reads 0 performs no command and sets bit 16 instead.
- R6: Writing 1 to bit 8 sets power, and writing 1 to bit 9 clears power. When both are written together, power ends cleared.
- R7: Bits 15 to 10, and every bit not listed in R2, read as 0. Writing 1 to them changes nothing.
- R8: On a suspended port, writing 1 to bit 3 starts the resume sequence. `resume_drive` stays high until `RESUME_MS` ticks have been seen. Then `eop_pulse` is high for one cycle. After `RESYNC_MS` further ticks, `resume_done` is high for one cycle. On the next edge, bit 2 clears and bit 18 sets.
- R9: Writing 1 to bit 4 on a connected port sets bit 4 and raises `port_reset`. A `reset_done` pulse then clears both, sets bits 1 and 20, clears bit 2 and clears bit 18.
- R10: With `FIXED_DEVICE` = 1, attach and detach do not set bit 16. A `hub_reset` pulse sets bit 16 while connected. With `FIXED_DEVICE` = 0, `hub_reset` has no effect.
- R11: A detach during a resume sequence aborts it: `resume_drive` drops and no `resume_done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Command word, one command per bit written as 1 |
| rd_data | output | 32 | Status word |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ev_attach | input | 1 | Device attach strobe |
| ls_detect | input | 1 | Low-speed line state, sampled on attach |
| ev_detach | input | 1 | Device detach strobe |
| hw_disable | input | 1 | Hardware port-disable strobe (e.g. babble) |
| hub_reset | input | 1 | Root hub reset completion strobe |
| reset_done | input | 1 | Port reset completion strobe |
| port_reset | output | 1 | Port reset requested |
| resume_drive | output | 1 | Resume signalling active |
| eop_pulse | output | 1 | One-cycle low-speed end-of-packet request |
| resume_done | output | 1 | One-cycle resume completion pulse |

## Verification
The assertions check the following on every cycle:
- a disable command never raises the enable change flag;
- a flag not written with 1 holds its value;
- the low-speed flag never stands without a connection;
- a detach clears the connection and enable on the next edge;
- the resume sequencer moves only through its legal phase order.

Only the bench scenarios show the remaining behaviour: the exact tick counts of each resume phase, the abort on detach, and the illegal-command response across every write bit. The same applies to the clear of every combination of change flags and the difference between removable and fixed configurations.

// File: rtl/rhps_pkg.sv
package rhps_pkg;

  localparam int REG_W        = 32;
  localparam int IDX_CONN     = 0;   // read: connected, write: disable port
  localparam int IDX_EN       = 1;   // read: enabled,   write: enable port
  localparam int IDX_SUSP     = 2;   // read: suspended, write: suspend port
  localparam int IDX_RESUME   = 3;   // read: resume busy, write: start resume
  localparam int IDX_RST      = 4;   // read: reset busy, write: start reset
  localparam int IDX_PWR      = 8;   // read: powered,   write: power on
  localparam int IDX_LOSPD    = 9;   // read: low speed, write: power off
  localparam int IDX_CONN_CHG = 16;
  localparam int IDX_EN_CHG   = 17;
  localparam int IDX_SUSP_CHG = 18;
  localparam int IDX_RST_CHG  = 20;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_DRIVE  = 2'd1,
    RS_EOP    = 2'd2,
    RS_RESYNC = 2'd3
  } rsm_state_e;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic start_resume;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
  } port_cmd_t;

  typedef struct packed {
    logic conn;
    logic en;
    logic susp;
    logic rst;
  } chg_t;

endpackage

// File: rtl/rhps_cmd_decode.sv
module rhps_cmd_decode
  import rhps_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             conn,
  output port_cmd_t        cmd,
  output logic             illegal,
  output chg_t             chg_clr
);

  logic [REG_W-1:0] w;
  logic             unused_bits;

  assign w = wr_en ? wr_data : '0;
  assign unused_bits = ^{w[REG_W-1:IDX_RST_CHG+1], w[IDX_RST_CHG-1:IDX_SUSP_CHG+1],
                         w[IDX_CONN_CHG-1:IDX_LOSPD+1], w[IDX_PWR-1:IDX_RST+1]};

  always_comb begin
    cmd.clr_en       = w[IDX_CONN];
    cmd.set_en       = w[IDX_EN]   & conn;
    cmd.set_susp     = w[IDX_SUSP] & conn;
    cmd.start_resume = w[IDX_RESUME];
    cmd.set_rst      = w[IDX_RST]  & conn;
    cmd.set_pwr      = w[IDX_PWR];
    cmd.clr_pwr      = w[IDX_LOSPD];
    // a state-changing command on an empty port is refused and flagged
    illegal          = ~conn & (w[IDX_EN] | w[IDX_SUSP] | w[IDX_RST]);
    chg_clr.conn     = w[IDX_CONN_CHG];
    chg_clr.en       = w[IDX_EN_CHG];
    chg_clr.susp     = w[IDX_SUSP_CHG];
    chg_clr.rst      = w[IDX_RST_CHG];
  end

endmodule

// File: rtl/rhps_resume_seq.sv
module rhps_resume_seq
  import rhps_pkg::*;
#(
  parameter int RESUME_MS = 20,
  parameter int RESYNC_MS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic ms_tick,
  output logic drive,
  output logic eop,
  output logic busy,
  output logic done
);

  localparam int MAX_MS = (RESUME_MS > RESYNC_MS) ? RESUME_MS : RESYNC_MS;
  localparam int CW     = $clog2(MAX_MS + 1);
  localparam logic [CW-1:0] LAST_DRV  = CW'(RESUME_MS - 1);
  localparam logic [CW-1:0] LAST_SYNC = CW'(RESYNC_MS - 1);

  rsm_state_e    state;
  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        state <= RS_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          RS_IDLE: if (start) begin
            state <= RS_DRIVE;
            cnt   <= '0;
          end
          RS_DRIVE: if (ms_tick) begin
            if (cnt == LAST_DRV) begin
              state <= RS_EOP;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RS_EOP: begin
            state <= RS_RESYNC;
            cnt   <= '0;
          end
          RS_RESYNC: if (ms_tick) begin
            if (cnt == LAST_SYNC) begin
              state  <= RS_IDLE;
              cnt    <= '0;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RS_IDLE;
        endcase
      end
    end
  end

  assign drive = (state == RS_DRIVE);
  assign eop   = (state == RS_EOP);
  assign busy  = (state != RS_IDLE);
  assign done  = done_q;

  // R8: drive phase never outlasts its tick budget
  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_DRIVE) |-> (32'(cnt) < RESUME_MS));
  // R8: completion only ever follows the resync phase
  assert_done_after_resync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state) == RS_RESYNC));
  // R8: the end-of-packet request lasts exactly one cycle
  assert_eop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !abort) |=> (state == RS_RESYNC));
  // R11: an abort always returns the sequencer to idle
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == RS_IDLE && !done_q));

endmodule

// File: rtl/rhps_port_state.sv
module rhps_port_state
  import rhps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cmd_t cmd,
  input  logic      ev_attach,
  input  logic      ls_detect,
  input  logic      ev_detach,
  input  logic      hw_disable,
  input  logic      reset_done,
  input  logic      resume_done,
  output logic      conn,
  output logic      en,
  output logic      susp,
  output logic      rst,
  output logic      pwr,
  output logic      lospd,
  output logic      en_lost,
  output logic      rst_fin
);

  assign en_lost = en & (ev_detach | hw_disable);
  assign rst_fin = rst & reset_done & ~ev_detach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn  <= 1'b0;
      en    <= 1'b0;
      susp  <= 1'b0;
      rst   <= 1'b0;
      lospd <= 1'b0;
    end else if (ev_detach) begin
      conn  <= 1'b0;
      en    <= 1'b0;
      susp  <= 1'b0;
      rst   <= 1'b0;
      lospd <= 1'b0;
    end else begin
      if (ev_attach) begin
        conn  <= 1'b1;
        lospd <= ls_detect;
      end
      if (cmd.set_en) en <= 1'b1;
      if (cmd.clr_en || hw_disable) en <= 1'b0;
      if (cmd.set_susp) susp <= 1'b1;
      if (resume_done) susp <= 1'b0;
      if (cmd.set_rst) rst <= 1'b1;
      if (rst_fin) begin
        rst  <= 1'b0;
        en   <= 1'b1;
        susp <= 1'b0;
      end
    end
  end

  // power is independent of the line state; clearing wins a tie
  always_ff @(posedge clk) begin
    if (!rst_n)           pwr <= 1'b0;
    else if (cmd.clr_pwr) pwr <= 1'b0;
    else if (cmd.set_pwr) pwr <= 1'b1;
  end

  // R2: the speed flag never stands without a device
  assert_lospd_needs_conn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conn |-> !lospd);
  // R2: a detach empties the port on the next edge
  assert_detach_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detach |=> (!conn && !en && !susp && !rst));
  // R6: a power-off command always lands
  assert_pwr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr_pwr |=> !pwr);

endmodule

// File: rtl/rhps_change_bits.sv
module rhps_change_bits
  import rhps_pkg::*;
#(
  parameter bit FIXED_DEVICE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_evt,
  input  logic illegal,
  input  logic hub_reset,
  input  logic conn,
  input  logic en_lost,
  input  logic susp_done,
  input  logic rst_done,
  input  chg_t chg_clr,
  output chg_t chg
);

  logic set_conn;

  generate
    if (FIXED_DEVICE) begin : g_fixed
      assign set_conn = illegal | (hub_reset & conn);
    end else begin : g_removable
      assign set_conn = illegal | conn_evt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg <= '0;
    end else begin
      if (set_conn)          chg.conn <= 1'b1;
      else if (chg_clr.conn) chg.conn <= 1'b0;

      if (en_lost)           chg.en <= 1'b1;
      else if (chg_clr.en)   chg.en <= 1'b0;

      if (rst_done)          chg.susp <= 1'b0;
      else if (susp_done)    chg.susp <= 1'b1;
      else if (chg_clr.susp) chg.susp <= 1'b0;

      if (rst_done)          chg.rst <= 1'b1;
      else if (chg_clr.rst)  chg.rst <= 1'b0;
    end
  end

  // R3: a flag not written with 1 and not hit by reset completion holds
  assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg.conn && !chg_clr.conn) |=> chg.conn);
  assert_w0_keeps_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg.en && !chg_clr.en) |=> chg.en);
  // R9: reset completion drops the suspend-change flag
  assert_pssc_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg.rst) |-> !chg.susp);
  // R10: in the removable variant attach or detach always raises connect change
  assert_conn_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_evt && !FIXED_DEVICE) |=> chg.conn);

endmodule

// File: rtl/rh_port_stat_reg.sv
module rh_port_stat_reg
  import rhps_pkg::*;
#(
  parameter int RESUME_MS    = 20,
  parameter int RESYNC_MS    = 3,
  parameter bit FIXED_DEVICE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ms_tick,
  input  logic             ev_attach,
  input  logic             ls_detect,
  input  logic             ev_detach,
  input  logic             hw_disable,
  input  logic             hub_reset,
  input  logic             reset_done,
  output logic             port_reset,
  output logic             resume_drive,
  output logic             eop_pulse,
  output logic             resume_done
);

  port_cmd_t cmd;
  chg_t      chg_clr, chg;
  logic      illegal;
  logic      conn, en, susp, rst, pwr, lospd;
  logic      en_lost, rst_fin;
  logic      rsm_busy, rsm_done, rsm_start;

  rhps_cmd_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .conn    (conn),
    .cmd     (cmd),
    .illegal (illegal),
    .chg_clr (chg_clr)
  );

  assign rsm_start = cmd.start_resume & susp & ~rsm_busy & ~rsm_done & ~ev_detach;

  rhps_resume_seq #(
    .RESUME_MS (RESUME_MS),
    .RESYNC_MS (RESYNC_MS)
  ) u_rsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (rsm_start),
    .abort   (ev_detach),
    .ms_tick (ms_tick),
    .drive   (resume_drive),
    .eop     (eop_pulse),
    .busy    (rsm_busy),
    .done    (rsm_done)
  );

  rhps_port_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .ev_attach   (ev_attach),
    .ls_detect   (ls_detect),
    .ev_detach   (ev_detach),
    .hw_disable  (hw_disable),
    .reset_done  (reset_done),
    .resume_done (rsm_done),
    .conn        (conn),
    .en          (en),
    .susp        (susp),
    .rst         (rst),
    .pwr         (pwr),
    .lospd       (lospd),
    .en_lost     (en_lost),
    .rst_fin     (rst_fin)
  );

  rhps_change_bits #(
    .FIXED_DEVICE (FIXED_DEVICE)
  ) u_chg (
    .clk       (clk),
    .rst_n     (rst_n),
    .conn_evt  (ev_attach | ev_detach),
    .illegal   (illegal),
    .hub_reset (hub_reset),
    .conn      (conn),
    .en_lost   (en_lost),
    .susp_done (rsm_done),
    .rst_done  (rst_fin),
    .chg_clr   (chg_clr),
    .chg       (chg)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[IDX_CONN]     = conn;
    rd_data[IDX_EN]       = en;
    rd_data[IDX_SUSP]     = susp;
    rd_data[IDX_RESUME]   = rsm_busy;
    rd_data[IDX_RST]      = rst;
    rd_data[IDX_PWR]      = pwr;
    rd_data[IDX_LOSPD]    = lospd;
    rd_data[IDX_CONN_CHG] = chg.conn;
    rd_data[IDX_EN_CHG]   = chg.en;
    rd_data[IDX_SUSP_CHG] = chg.susp;
    rd_data[IDX_RST_CHG]  = chg.rst;
  end

  assign port_reset  = rst;
  assign resume_done = rsm_done;

  // R4: a software disable never raises the enable change flag
  assert_sw_disable_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[IDX_CONN] && !hw_disable && !ev_detach && !rd_data[IDX_EN_CHG])
    |=> !rd_data[IDX_EN_CHG]);
  // R5: a refused command leaves the empty port unreset
  assert_refused_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[IDX_RST] && !rd_data[IDX_CONN] && !port_reset) |=> !port_reset);
  // R7: reserved positions stay zero
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:10] == '0);
  // R8: resume phases are mutually exclusive at the pins
  assert_phase_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_drive, eop_pulse, resume_done}));

endmodule

// File: tb/rh_port_stat_reg_tb_top.sv
module rh_port_stat_reg_tb_top;

  localparam int RES_MS  = 4;
  localparam int SYNC_MS = 2;
  localparam logic [31:0] B_CONN = 32'h1,     B_EN = 32'h2,       B_SUSP = 32'h4;
  localparam logic [31:0] B_RSM  = 32'h8,     B_RST = 32'h10,     B_PWR  = 32'h100;
  localparam logic [31:0] B_LS   = 32'h200,   B_CSC = 32'h10000,  B_PESC = 32'h20000;
  localparam logic [31:0] B_PSSC = 32'h40000, B_PRSC = 32'h100000;
  localparam logic [31:0] ALL_CHG = B_CSC | B_PESC | B_PSSC | B_PRSC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0, ms_tick = 1'b0;
  logic [31:0] wr_data = '0, rd, rd_fx;
  logic        ev_attach = 1'b0, ls_detect = 1'b0, ev_detach = 1'b0;
  logic        hw_disable = 1'b0, hub_reset = 1'b0, reset_done = 1'b0;
  logic        port_reset, resume_drive, eop_pulse, resume_done;
  logic        fx_prst, fx_drv, fx_eop, fx_done;

  int errs = 0, checks = 0, eop_cnt = 0, done_cnt = 0;

  rh_port_stat_reg #(.RESUME_MS(RES_MS), .RESYNC_MS(SYNC_MS), .FIXED_DEVICE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd),
    .ms_tick(ms_tick), .ev_attach(ev_attach), .ls_detect(ls_detect), .ev_detach(ev_detach),
    .hw_disable(hw_disable), .hub_reset(hub_reset), .reset_done(reset_done),
    .port_reset(port_reset), .resume_drive(resume_drive), .eop_pulse(eop_pulse),
    .resume_done(resume_done));

  rh_port_stat_reg #(.RESUME_MS(RES_MS), .RESYNC_MS(SYNC_MS), .FIXED_DEVICE(1'b1)) dut_fx_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_fx),
    .ms_tick(ms_tick), .ev_attach(ev_attach), .ls_detect(ls_detect), .ev_detach(ev_detach),
    .hw_disable(hw_disable), .hub_reset(hub_reset), .reset_done(reset_done),
    .port_reset(fx_prst), .resume_drive(fx_drv), .eop_pulse(fx_eop),
    .resume_done(fx_done));

  always @(negedge clk) begin
    if (eop_pulse)   eop_cnt++;
    if (resume_done) done_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic attach(input logic ls);
    ev_attach = 1'b1; ls_detect = ls;
    @(negedge clk);
    ev_attach = 1'b0; ls_detect = 1'b0;
  endtask

  task automatic detach();
    ev_detach = 1'b1; @(negedge clk); ev_detach = 1'b0;
  endtask

  task automatic hwdis();
    hw_disable = 1'b1; @(negedge clk); hw_disable = 1'b0;
  endtask

  task automatic rstdone();
    reset_done = 1'b1; @(negedge clk); reset_done = 1'b0;
  endtask

  task automatic hubrst();
    hub_reset = 1'b1; @(negedge clk); hub_reset = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
  endtask

  // full resume on a connected port; base_state is the word before suspending
  task automatic do_resume(input int gap, input logic [31:0] base_state);
    int d0, e0;
    wr(B_SUSP);
    chk("R8 suspend set", rd, base_state | B_SUSP);
    d0 = done_cnt; e0 = eop_cnt;
    wr(B_RSM);
    chk("R8 resume busy", rd, base_state | B_SUSP | B_RSM);
    chk("R8 drive on", 32'(resume_drive), 32'd1);
    for (int k = 1; k < RES_MS; k++) begin
      tick();
      chk("R8 drive held", {30'd0, resume_drive, rd[2]}, 32'd3);
      idle(gap);
    end
    tick();
    chk("R8 eop after drive", {30'd0, resume_drive, eop_pulse}, 32'd1);
    idle(1);
    chk("R8 eop single", 32'(eop_pulse), 32'd0);
    for (int k = 1; k < SYNC_MS; k++) begin
      tick();
      chk("R8 no early done", {30'd0, resume_done, rd[2]}, 32'd1);
      idle(gap);
    end
    tick();
    chk("R8 done pulse", {30'd0, resume_done, rd[2]}, 32'd3);
    idle(1);
    chk("R8 resume complete", rd, base_state | B_PSSC);
    chk("R8 pulse counts", (done_cnt - d0) * 16 + (eop_cnt - e0), 32'd17);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset word", rd, 32'd0);
    chk("R1 reset outputs", {28'd0, port_reset, resume_drive, eop_pulse, resume_done}, 32'd0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after release", rd, 32'd0);

    // R6 power on, R7 reserved ignored
    wr(B_PWR);
    chk("R6 power on", rd, B_PWR);
    wr(32'h0000_FC00);
    chk("R7 reserved write", rd, B_PWR);

    // sweep every write bit on an empty powered port
    for (int b = 0; b < 32; b++) begin
      logic [31:0] exp;
      wr(32'd1 << b);
      if (b == 1 || b == 2 || b == 4) exp = B_PWR | B_CSC;
      else if (b == 9)                exp = 32'd0;
      else                            exp = B_PWR;
      chk($sformatf("R5 R6 R7 bit %0d", b), rd, exp);
      chk("R5 no reset on empty port", 32'(port_reset), 32'd0);
      wr(B_PWR | B_CSC);
      chk("R3 restore", rd, B_PWR);
    end
    wr(B_PWR | B_LS);
    chk("R6 on and off together", rd, 32'd0);
    wr(B_PWR);

    // attach and detach with both speeds
    for (int ls = 0; ls < 2; ls++) begin
      attach(ls[0]);
      chk("R2 attach", rd, B_CONN | B_PWR | B_CSC | (ls[0] ? B_LS : 32'd0));
      wr(32'd0);
      chk("R3 write zero keeps", rd, B_CONN | B_PWR | B_CSC | (ls[0] ? B_LS : 32'd0));
      wr(B_CSC);
      chk("R3 clear connect change", rd, B_CONN | B_PWR | (ls[0] ? B_LS : 32'd0));
      detach();
      chk("R2 detach", rd, B_PWR | B_CSC);
      wr(B_CSC);
    end

    // enable handling
    attach(1'b0); wr(B_CSC);
    wr(B_EN);
    chk("R4 software enable", rd, B_CONN | B_EN | B_PWR);
    wr(B_CONN);
    chk("R4 software disable quiet", rd, B_CONN | B_PWR);
    wr(B_EN); hwdis();
    chk("R4 hardware disable", rd, B_CONN | B_PWR | B_PESC);
    wr(B_PESC);
    chk("R3 clear enable change", rd, B_CONN | B_PWR);
    hwdis();
    chk("R4 disable while disabled", rd, B_CONN | B_PWR);
    wr(B_EN); detach();
    chk("R2 detach while enabled", rd, B_PWR | B_CSC | B_PESC);
    wr(ALL_CHG);
    chk("R3 clear all", rd, B_PWR);

    // port reset
    attach(1'b0); wr(B_CSC);
    wr(B_RST);
    chk("R9 reset started", rd, B_CONN | B_PWR | B_RST);
    chk("R9 reset pin", 32'(port_reset), 32'd1);
    rstdone();
    chk("R9 reset finished", rd, B_CONN | B_EN | B_PWR | B_PRSC);
    chk("R9 reset pin low", 32'(port_reset), 32'd0);
    wr(B_PRSC);

    // resume with two tick spacings
    do_resume(0, B_CONN | B_EN | B_PWR);
    wr(B_PSSC);
    do_resume(2, B_CONN | B_EN | B_PWR);
    wr(B_RST); rstdone();
    chk("R9 reset drops suspend change", rd, B_CONN | B_EN | B_PWR | B_PRSC);
    wr(B_PRSC); detach(); wr(ALL_CHG);

    // abort of a resume
    attach(1'b0); wr(B_CSC);
    begin
      int d0;
      d0 = done_cnt;
      wr(B_SUSP); wr(B_RSM); tick(); tick();
      detach();
      chk("R11 abort state", rd, B_PWR | B_CSC);
      chk("R11 drive dropped", 32'(resume_drive), 32'd0);
      for (int k = 0; k < RES_MS + SYNC_MS + 2; k++) begin tick(); idle(1); end
      chk("R11 no completion", 32'(done_cnt - d0), 32'd0);
    end
    wr(ALL_CHG);

    // every combination of change-flag clears
    for (int m = 0; m < 16; m++) begin
      logic [31:0] mask, full;
      full = B_CONN | B_PWR | ALL_CHG;
      attach(1'b0);
      wr(B_RST); rstdone();
      do_resume(0, B_CONN | B_EN | B_PWR | B_CSC | B_PRSC);
      hwdis();
      chk("R3 setup all flags", rd, full);
      mask = (m[0] ? B_CSC : 32'd0) | (m[1] ? B_PESC : 32'd0) |
             (m[2] ? B_PSSC : 32'd0) | (m[3] ? B_PRSC : 32'd0);
      wr(mask);
      chk($sformatf("R3 clear mask %0d", m), rd, full & ~mask);
      detach(); wr(ALL_CHG);
    end

    // fixed-device variant
    chk("R10 clean start", rd_fx, B_PWR);
    attach(1'b1);
    chk("R10 fixed attach quiet", rd_fx, B_CONN | B_PWR | B_LS);
    chk("R10 removable attach", rd, B_CONN | B_PWR | B_LS | B_CSC);
    hubrst();
    chk("R10 fixed hub reset", rd_fx, B_CONN | B_PWR | B_LS | B_CSC);
    chk("R10 removable hub reset ignored", rd, B_CONN | B_PWR | B_LS | B_CSC);
    wr(B_CSC); detach();
    chk("R10 fixed detach quiet", rd_fx, B_PWR);
    hubrst();
    chk("R10 hub reset while empty", rd_fx, B_PWR);

    summary();
    $finish;
  end

endmodule